// File: doc/BRIEF.md
# Receive packet FIFO status tracker

This block follows how full a receive packet FIFO is, counting both stored packets and stored bytes, without holding the data itself. Bytes arrive one per pulse from the wire side. The last byte of each packet carries a 4-bit error code. The host drains bytes one read strobe at a time and can drop the oldest packet with a single discard command. The block gives the host a 16-bit status word for the oldest packet. It also drives diagnostic flags for packet-count overrun, byte-storage overrun and host read underrun, plus a flag that is high while a packet is being written.

The tracker stops accepting new packets in two cases: the packet limit is reached, or byte storage is full. Storage reopens after a removal, or once enough bytes have drained. A packet that begins while acceptance is blocked is dropped in full and leaves no entry. A host read beyond the data received so far raises a sticky failure. Only a receive-reset command or the chip reset clears it.

Top module: `rx_fifo_status_tracker`

## Requirements
- R1: After `rst_n` is released, `status` is 16'h8000 and `receiving`, `pkt_limit`, `rx_overrun`, `rx_underrun` and `adapter_fail` are all low.
- R2: While no complete packet is held, `status` bit 15 is 1, bits 14:11 are 0, and bits 10:0 give the bytes of the packet still being written that are not yet read (0 when the FIFO is empty).
- R3: While a complete packet is held, `status` bit 15 is 0, bits 14:11 hold the 4-bit code that came with the packet's last byte (overrun 1000, runt 1011, alignment 1100, CRC 1101, oversize 1001, dribble 0010), and bits 10:0 hold that packet's unread byte count.
- R4: Each accepted host read lowers the top packet's byte count by one. A fully read packet stays at the top with count 0 until it is discarded.
- R5: A discard removes the oldest complete packet and frees its remaining bytes, so the next packet becomes the top. A discard with no complete packet has no effect. A read in the same cycle as a discard is ignored.
- R6: `pkt_limit` is high while MAX_PKTS complete packets are held. A packet that starts while it is high is dropped entirely. The flag falls after one discard.
- R7: `rx_overrun` rises when byte occupancy reaches BYTE_CAP. A packet that starts while it is high is dropped entirely. The flag falls once occupancy is at or below BYTE_CAP minus RESUME_BYTES.
- R8: A byte that arrives in the middle of a packet while storage is full is lost, and that packet is stored with code 1000.
- R9: A host read when the top count is 0 sets `rx_underrun` and `adapter_fail`. Both stay set through later traffic until `rx_reset` or `rst_n`.
- R10: `receiving` rises the cycle after the first accepted byte of a packet that has more than one byte. It falls the cycle after that packet's last byte. It never rises for a one-byte packet or for a dropped packet.
- R11: `rx_reset` empties the FIFO and abandons any packet in progress. Next cycle `status` is 16'h8000 and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte | input | 1 | One received byte arrives this cycle |
| wr_last | input | 1 | The arriving byte ends its packet |
| wr_code | input | 4 | Error code tagged on the last byte |
| rd_byte | input | 1 | Host reads one byte of the top packet |
| discard | input | 1 | Drop the oldest complete packet |
| rx_reset | input | 1 | Receive-side reset command |
| status | output | 16 | Top packet status word |
| receiving | output | 1 | A packet is being written |
| pkt_limit | output | 1 | Packet-count limit reached |
| rx_overrun | output | 1 | Byte storage full, with hysteresis |
| rx_underrun | output | 1 | Sticky read-past-data flag |
| adapter_fail | output | 1 | Failure indication raised by underrun |

## Verification
A sweep sends packets of one to four bytes with every listed error code. Each byte is checked in progress, each read is checked, and a discard follows. This separates the in-progress view from the complete-packet view, checks the code placement, and shows whether one-byte packets ever raise `receiving`. A burst of nine short packets checks that only the ninth is dropped and that removal reopens acceptance. A fill to exactly the byte limit checks mid-packet truncation, the drop of a new packet, and the exact occupancy at which the overrun flag falls. Reads on empty or drained packets, then receive resets with and without data held, tell the sticky underrun apart from the ordinary flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_OVERRUN = 4'b1000;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
  } rxf_entry_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_FILL,
    WR_DROP
  } wr_state_e;

endpackage

// File: rtl/rxf_pkt_queue.sv
module rxf_pkt_queue
  import rxf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           push,
  input  rxf_entry_t                     push_entry,
  input  logic                           pop,
  input  logic                           dec_top,
  output rxf_entry_t                     top_entry,
  output logic                           empty,
  output logic                           full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rxf_entry_t       slot_view [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (clr) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) tail_d = bump(tail_q);
      if (pop)  head_d = bump(head_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rxf_entry_t slot_q, slot_d;
    logic       wr_en, dec_en;

    assign wr_en  = push && !clr && (tail_q == PTR_W'(i));
    assign dec_en = dec_top && !clr && (head_q == PTR_W'(i));

    always_comb begin
      slot_d = slot_q;
      if (wr_en)       slot_d = push_entry;
      else if (dec_en) slot_d.len = slot_q.len - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               slot_q <= '0;
      else if (wr_en || dec_en) slot_q <= slot_d;
    end

    assign slot_view[i] = slot_q;
  end

  assign top_entry = slot_view[head_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == FULL_CNT);

endmodule

// File: rtl/rxf_byte_meter.sv
module rxf_byte_meter
  import rxf_pkg::*;
#(
  parameter int BYTE_CAP     = 2000,
  parameter int RESUME_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic             sub1,
  input  logic             sub_pkt,
  input  logic [LEN_W-1:0] sub_len,
  output logic             space,
  output logic             ovr
);

  localparam int OCC_W = $clog2(BYTE_CAP + 1);
  localparam logic [OCC_W-1:0] CAP_V = OCC_W'(BYTE_CAP);
  localparam logic [OCC_W-1:0] LOW_V = OCC_W'(BYTE_CAP - RESUME_BYTES);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    occ_d = occ_q + OCC_W'(add) - OCC_W'(sub1)
          - (sub_pkt ? OCC_W'(sub_len) : '0);
    if (clr) occ_d = '0;

    ovr_d = ovr_q;
    if (clr)                 ovr_d = 1'b0;
    else if (occ_d >= CAP_V) ovr_d = 1'b1;
    else if (occ_d <= LOW_V) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
      ovr_q <= ovr_d;
    end
  end

  assign space = (occ_q < CAP_V);
  assign ovr   = ovr_q;

endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_byte,
  input  logic              wr_last,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              blocked,
  input  logic              space,
  input  logic              rd_inprog,
  output logic              store,
  output logic              push,
  output rxf_entry_t        push_entry,
  output logic [LEN_W-1:0]  inprog_len,
  output logic              filling
);

  wr_state_e        st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d, len_sum;
  logic             trunc_q, trunc_d;
  logic             lost;

  always_comb begin
    st_d    = st_q;
    trunc_d = trunc_q;
    store   = 1'b0;
    push    = 1'b0;
    lost    = 1'b0;
    case (st_q)
      WR_IDLE: if (wr_byte) begin
        if (blocked) begin
          if (!wr_last) st_d = WR_DROP;
        end else begin
          store = space;
          lost  = !space;
          if (wr_last) push = 1'b1;
          else         st_d = WR_FILL;
        end
      end
      WR_FILL: if (wr_byte) begin
        store = space;
        lost  = !space;
        if (wr_last) begin
          push = 1'b1;
          st_d = WR_IDLE;
        end
      end
      WR_DROP: if (wr_byte && wr_last) st_d = WR_IDLE;
      default: st_d = WR_IDLE;
    endcase

    len_sum         = len_q + LEN_W'(store) - LEN_W'(rd_inprog);
    push_entry.code = (trunc_q || lost) ? CODE_OVERRUN : wr_code;
    push_entry.len  = len_sum;

    if (push) begin
      len_d   = '0;
      trunc_d = 1'b0;
    end else begin
      len_d = len_sum;
      if (lost) trunc_d = 1'b1;
    end

    if (clr) begin
      st_d    = WR_IDLE;
      len_d   = '0;
      trunc_d = 1'b0;
      push    = 1'b0;
      store   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_IDLE;
      len_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      len_q   <= len_d;
      trunc_q <= trunc_d;
    end
  end

  assign inprog_len = len_q;
  assign filling    = (st_q == WR_FILL);

endmodule

// File: rtl/rx_fifo_status_tracker.sv
module rx_fifo_status_tracker
  import rxf_pkg::*;
#(
  parameter int BYTE_CAP     = 2000,
  parameter int MAX_PKTS     = 8,
  parameter int RESUME_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_byte,
  input  logic        wr_last,
  input  logic [3:0]  wr_code,
  input  logic        rd_byte,
  input  logic        discard,
  input  logic        rx_reset,
  output logic [15:0] status,
  output logic        receiving,
  output logic        pkt_limit,
  output logic        rx_overrun,
  output logic        rx_underrun,
  output logic        adapter_fail
);

  rxf_entry_t       top_entry, push_entry;
  logic             q_empty, q_full;
  logic             store, push, filling;
  logic [LEN_W-1:0] inprog_len, top_len;
  logic             space, ovr;
  logic             has_pkt, rd_req, rd_ok, dec_top, rd_inprog, pop;
  logic             und_q, und_d;

  assign has_pkt   = !q_empty;
  assign top_len   = has_pkt ? top_entry.len : inprog_len;
  assign rd_req    = rd_byte && !discard && !rx_reset;
  assign rd_ok     = rd_req && (top_len != '0);
  assign dec_top   = rd_ok && has_pkt;
  assign rd_inprog = rd_ok && !has_pkt;
  assign pop       = discard && has_pkt && !rx_reset;

  rxf_wr_ctrl u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rx_reset),
    .wr_byte    (wr_byte && !rx_reset),
    .wr_last    (wr_last),
    .wr_code    (wr_code),
    .blocked    (q_full || ovr),
    .space      (space),
    .rd_inprog  (rd_inprog),
    .store      (store),
    .push       (push),
    .push_entry (push_entry),
    .inprog_len (inprog_len),
    .filling    (filling)
  );

  rxf_pkt_queue #(.DEPTH(MAX_PKTS)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rx_reset),
    .push       (push),
    .push_entry (push_entry),
    .pop        (pop),
    .dec_top    (dec_top),
    .top_entry  (top_entry),
    .empty      (q_empty),
    .full       (q_full)
  );

  rxf_byte_meter #(.BYTE_CAP(BYTE_CAP), .RESUME_BYTES(RESUME_BYTES)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rx_reset),
    .add     (store),
    .sub1    (rd_ok),
    .sub_pkt (pop),
    .sub_len (top_entry.len),
    .space   (space),
    .ovr     (ovr)
  );

  always_comb begin
    und_d = und_q;
    if (rx_reset)                      und_d = 1'b0;
    else if (rd_req && top_len == '0)  und_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) und_q <= 1'b0;
    else        und_q <= und_d;
  end

  assign status       = has_pkt ? {1'b0, top_entry.code, top_entry.len}
                                : {1'b1, 4'b0000, inprog_len};
  assign receiving    = filling;
  assign pkt_limit    = q_full;
  assign rx_overrun   = ovr;
  assign rx_underrun  = und_q;
  assign adapter_fail = und_q;

endmodule

module rxf_tracker_chk #(
  parameter int BYTE_CAP = 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_byte,
  input logic        wr_last,
  input logic        rd_byte,
  input logic        discard,
  input logic        rx_reset,
  input logic [15:0] status,
  input logic        receiving,
  input logic        pkt_limit,
  input logic        rx_overrun,
  input logic        rx_underrun
);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun && !rx_reset |=> rx_underrun);

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte && !discard && !rx_reset && status[10:0] == 11'd0 |=> rx_underrun);

  // R11
  rx_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (status == 16'h8000 && !rx_overrun && !pkt_limit
                  && !rx_underrun && !receiving));

  // R7
  overrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(wr_byte));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[10:0] <= 11'(BYTE_CAP));

  // R10
  receiving_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(receiving) |-> $past(wr_byte && !wr_last));

  // R6
  limit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_limit && wr_byte && !receiving |=> !receiving);

endmodule

bind rx_fifo_status_tracker rxf_tracker_chk #(.BYTE_CAP(BYTE_CAP)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_byte     (wr_byte),
  .wr_last     (wr_last),
  .rd_byte     (rd_byte),
  .discard     (discard),
  .rx_reset    (rx_reset),
  .status      (status),
  .receiving   (receiving),
  .pkt_limit   (pkt_limit),
  .rx_overrun  (rx_overrun),
  .rx_underrun (rx_underrun)
);

// File: tb/test_rx_fifo_status_tracker.sv
module test_rx_fifo_status_tracker;

  localparam int CAP = 32;
  localparam int PKTS = 8;
  localparam int RES = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_byte, wr_last, rd_byte, discard, rx_reset;
  logic [3:0]  wr_code;
  logic [15:0] status;
  logic        receiving, pkt_limit, rx_overrun, rx_underrun, adapter_fail;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rx_fifo_status_tracker #(.BYTE_CAP(CAP), .MAX_PKTS(PKTS), .RESUME_BYTES(RES))
  i_rx_fifo_status_tracker (
    .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wr_last(wr_last),
    .wr_code(wr_code), .rd_byte(rd_byte), .discard(discard),
    .rx_reset(rx_reset), .status(status), .receiving(receiving),
    .pkt_limit(pkt_limit), .rx_overrun(rx_overrun),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wb, input logic wl, input logic [3:0] wc,
                       input logic rd, input logic dc, input logic rr);
    @(negedge clk);
    wr_byte = wb; wr_last = wl; wr_code = wc;
    rd_byte = rd; discard = dc; rx_reset = rr;
    @(posedge clk);
    #2;
    wr_byte = 0; wr_last = 0; wr_code = 0;
    rd_byte = 0; discard = 0; rx_reset = 0;
  endtask

  task automatic send(input int len, input logic [3:0] code);
    for (int b = 1; b <= len; b++) drive(1, b == len, code, 0, 0, 0);
  endtask

  function automatic logic [15:0] done_word(input logic [3:0] c, input int n);
    return {1'b0, c, 11'(n)};
  endfunction

  logic [3:0] codes [6];

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    codes = '{4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010};
    rst_n = 0;
    wr_byte = 0; wr_last = 0; wr_code = 0; rd_byte = 0; discard = 0; rx_reset = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #20;

    // R1 reset state
    chk("R1 status", 32'(status), 32'h8000);
    chk("R1 flags", {receiving, pkt_limit, rx_overrun, rx_underrun, adapter_fail}, 0);

    // R5 discard on empty FIFO has no effect
    drive(0, 0, 0, 0, 1, 0);
    chk("R5 empty discard", 32'(status), 32'h8000);

    // Sweep: every code, lengths 1..4
    for (int ci = 0; ci < 6; ci++) begin
      for (int len = 1; len <= 4; len++) begin
        for (int b = 1; b <= len; b++) begin
          drive(1, b == len, codes[ci], 0, 0, 0);
          if (b < len) begin
            chk("R2 in-progress word", 32'(status), 32'({1'b1, 4'b0, 11'(b)}));
            chk("R10 receiving high", 32'(receiving), 1);
          end
        end
        chk("R3 complete word", 32'(status), 32'(done_word(codes[ci], len)));
        chk("R10 receiving low", 32'(receiving), 0);
        for (int r = 1; r <= len; r++) begin
          drive(0, 0, 0, 1, 0, 0);
          chk("R4 count after read", 32'(status), 32'(done_word(codes[ci], len - r)));
        end
        drive(0, 0, 0, 1, 1, 0);
        chk("R5 discard pops", 32'(status), 32'h8000);
        chk("R5 read with discard ignored", 32'(rx_underrun), 0);
      end
    end

    // R6 packet limit
    for (int p = 0; p < PKTS; p++) send(2, 4'(p));
    chk("R6 limit set", 32'(pkt_limit), 1);
    send(3, 4'hF);
    chk("R6 drop keeps top", 32'(status), 32'(done_word(4'd0, 2)));
    chk("R6 no receiving on drop", 32'(receiving), 0);
    drive(0, 0, 0, 0, 1, 0);
    chk("R6 limit clears", 32'(pkt_limit), 0);
    chk("R5 next becomes top", 32'(status), 32'(done_word(4'd1, 2)));
    for (int p = 1; p < PKTS; p++) drive(0, 0, 0, 0, 1, 0);
    chk("R6 dropped packet absent", 32'(status), 32'h8000);

    // R7 / R8 byte storage full
    send(CAP - 2, 4'b0000);
    chk("R7 below cap", 32'(rx_overrun), 0);
    send(5, 4'b1101);
    chk("R7 overrun set", 32'(rx_overrun), 1);
    send(1, 4'b1011);
    for (int r = 1; r <= RES - 1; r++) drive(0, 0, 0, 1, 0, 0);
    chk("R7 hysteresis holds", 32'(rx_overrun), 1);
    drive(0, 0, 0, 1, 0, 0);
    chk("R7 overrun clears", 32'(rx_overrun), 0);
    chk("R4 top partial read", 32'(status), 32'(done_word(4'b0000, CAP - 2 - RES)));
    drive(0, 0, 0, 0, 1, 0);
    chk("R8 truncated packet", 32'(status), 32'(done_word(4'b1000, 2)));
    drive(0, 0, 0, 0, 1, 0);
    chk("R7 blocked packet dropped", 32'(status), 32'h8000);

    // R9 underrun
    drive(0, 0, 0, 1, 0, 0);
    chk("R9 underrun set", {rx_underrun, adapter_fail}, 2'b11);
    send(2, 4'b0000);
    drive(0, 0, 0, 0, 1, 0);
    chk("R9 underrun sticky", {rx_underrun, adapter_fail}, 2'b11);
    drive(0, 0, 0, 0, 0, 1);
    chk("R9 rx_reset clears", {rx_underrun, adapter_fail}, 2'b00);

    // R11 reset with data held and a packet in progress
    send(3, 4'b1100);
    drive(1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    chk("R11 status cleared", 32'(status), 32'h8000);
    chk("R11 flags cleared", {receiving, pkt_limit, rx_overrun, rx_underrun}, 0);
    send(1, 4'b1001);
    chk("R11 fresh packet", 32'(status), 32'(done_word(4'b1001, 1)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule